// File: doc/BRIEF.md
# Serial Bus PHY-Link Data Interface

This block sits on the link side of an IEEE 1394 style physical-layer device and runs entirely from the clock that the PHY supplies (nominally 49.152 MHz). It asks the PHY for the bus by sending a short serial frame on a single request line. It watches a 2-bit control bus that says which of four interface operations is in progress. It moves packet bytes across an 8-lane data bus, and a packet uses only as many lanes as its speed class needs.

On receive, the PHY puts a speed code on the data lanes in the first cycle. The block then collects 2, 4 or 8 bits per cycle and presents each completed byte on the link side. On status, the PHY shifts status bits in two at a time, and the block reports the collected word when the status operation closes. After the PHY grants the bus, the link owns the control and data lines. The block cuts each outgoing byte into slices that match the chosen speed, then hands the bus back.

Top module: `phylink_if`

## Requirements
- R1: While reset is asserted, and until the first grant or request, `ctl_oe`, `data_oe`, `lreq`, `req_busy`, `rx_valid`, `rx_end`, `stat_valid` and `tx_take` are 0 and `data_out` is 0.
- R2: Control codes are 00 idle, 01 status, 10 receive and 11 transmit (a grant when the PHY drives it). Only 10 starts a receive and only 01 starts a status collection.
- R3: On an accepted `req_go`, `lreq` shows, one bit per cycle starting the next cycle, a frame made of a 1 start bit, then `req_type` MSB first, then `req_data` MSB first, then a 0 stop bit. `req_busy` is high for exactly the frame length.
- R4: A `req_go` that arrives while `req_busy` is high is ignored, and the frame in flight is not altered.
- R5: In the first receive cycle, `data_in[1:0]` is the speed code. 00 selects lanes [1:0] (4 cycles per byte), 01 selects lanes [3:0] (2 cycles), and 10 or 11 selects all 8 lanes (1 cycle). The most significant slice comes first. `rx_valid` pulses with `rx_byte` in the cycle after the last slice is sampled.
- R6: The cycle after the control code leaves 10, `rx_end` pulses for one cycle. A byte whose slices are incomplete is discarded and produces no `rx_valid`.
- R7: During status (01), `data_in[1:0]` is shifted into a STAT_W-bit word that starts from zero, newest pair in the low bits. The cycle after status closes, `stat_valid` pulses and `stat_word` holds that word.
- R8: If a grant (11) is seen while the bus is idle and `tx_avail` is 1, then from the next cycle the block drives `ctl_out`=11 with `ctl_oe`/`data_oe` high. It sends each byte as slices of width 2, 4 or 8 selected by `tx_speed` (same codes as R5), most significant slice first, in the low lanes, with unused lanes 0. `tx_take` pulses in the first cycle of each byte, and the next byte and `tx_last` must be on `tx_data` before the following slice boundary.
- R9: After the last slice of the byte marked `tx_last`, the block drives `ctl_out`=00 with `data_out`=0 for one cycle and then releases both enables.
- R10: A grant seen with `tx_avail`=0 gives one cycle of `ctl_out`=00 with the enables high, then release, with no `tx_take`.
- R11: While the link owns the bus, `ctl_in` and `data_in` produce no `rx_valid`, `rx_end` or `stat_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_in | input | 2 | Control bus as driven by the PHY |
| ctl_out | output | 2 | Control bus value driven by the link |
| ctl_oe | output | 1 | Link drives the control bus |
| data_in | input | LANES | Data lanes as driven by the PHY |
| data_out | output | LANES | Data lanes driven by the link |
| data_oe | output | 1 | Link drives the data lanes |
| lreq | output | 1 | Serial request line to the PHY |
| req_go | input | 1 | Start a request frame |
| req_type | input | TYPE_W | Request-type field of the frame |
| req_data | input | DATA_W | Request payload field of the frame |
| req_busy | output | 1 | Request frame in flight |
| tx_speed | input | 2 | Speed code for the next transmit |
| tx_data | input | LANES | Byte to send |
| tx_last | input | 1 | `tx_data` is the final byte of the packet |
| tx_avail | input | 1 | `tx_data` holds a byte ready to send |
| tx_take | output | 1 | A byte was loaded for sending |
| rx_byte | output | LANES | Received byte |
| rx_valid | output | 1 | `rx_byte` is new this cycle |
| rx_end | output | 1 | Receive operation finished |
| stat_word | output | STAT_W | Collected status bits |
| stat_valid | output | 1 | `stat_word` is new this cycle |

## Verification
The request framer runs independently of the bus direction, so a frame can be shifting out on `lreq` in the same cycles that the receive path is assembling bytes. The bench starts a request in the same cycle as a full-width receive. It then checks each frame bit and each received byte cycle by cycle against values computed from R3 and R5. A second overlap happens while the link owns the bus: the bench drives a receive code and junk data under a transmit and requires the slices to be exact with no receive output at all.

// File: rtl/phylink_pkg.sv
package phylink_pkg;

  localparam logic [1:0] CTL_IDLE   = 2'b00;
  localparam logic [1:0] CTL_STATUS = 2'b01;
  localparam logic [1:0] CTL_RECV   = 2'b10;
  localparam logic [1:0] CTL_XMIT   = 2'b11;

  localparam logic [1:0] SPD_LOW = 2'b00;
  localparam logic [1:0] SPD_MID = 2'b01;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'b00,
    TX_SEND  = 2'b01,
    TX_CLOSE = 2'b10
  } tx_state_e;

endpackage

// File: rtl/phylink_lreq.sv
module phylink_lreq #(
  parameter int TYPE_W = 3,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [TYPE_W-1:0] rtype,
  input  logic [DATA_W-1:0] rdata,
  output logic              lreq,
  output logic              busy
);
  localparam int FRAME_LEN = TYPE_W + DATA_W + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;

  assign busy = (cnt_q != '0);
  assign lreq = busy & sh_q[FRAME_LEN-1];

  // frame: start bit, type field, data field, stop bit
  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (!busy && go) begin
      sh_d  = {1'b1, rtype, rdata, 1'b0};
      cnt_d = CNT_W'(FRAME_LEN);
    end else if (busy) begin
      sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/phylink_rx.sv
module phylink_rx
  import phylink_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctl,
  input  logic [LANES-1:0]  din,
  output logic [LANES-1:0]  rx_byte,
  output logic              rx_valid,
  output logic              rx_end,
  output logic [STAT_W-1:0] stat_word,
  output logic              stat_valid
);
  localparam int W_LOW = LANES / 4;
  localparam int W_MID = LANES / 2;

  logic              in_rx_q, in_rx_d;
  logic [1:0]        spd_q, spd_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [1:0]        last_idx;
  logic [LANES-1:0]  acc_q, acc_d, acc_shift;
  logic [LANES-1:0]  byte_q;
  logic              byte_ld;
  logic              valid_q, valid_d;
  logic              end_q, end_d;
  logic              in_st_q, in_st_d;
  logic [STAT_W-1:0] sacc_q, sacc_d;
  logic [STAT_W-1:0] word_q;
  logic              stat_ld;
  logic              sv_q, sv_d;

  // lane width per speed: constant shifts only, no barrel shifter
  always_comb begin
    case (spd_q)
      SPD_LOW: begin
        acc_shift = {acc_q[LANES-W_LOW-1:0], din[W_LOW-1:0]};
        last_idx  = 2'd3;
      end
      SPD_MID: begin
        acc_shift = {acc_q[LANES-W_MID-1:0], din[W_MID-1:0]};
        last_idx  = 2'd1;
      end
      default: begin
        acc_shift = din;
        last_idx  = 2'd0;
      end
    endcase
  end

  always_comb begin
    in_rx_d = in_rx_q;
    spd_d   = spd_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    byte_ld = 1'b0;
    valid_d = 1'b0;
    end_d   = 1'b0;
    if (ctl == CTL_RECV) begin
      if (!in_rx_q) begin
        in_rx_d = 1'b1;
        spd_d   = din[1:0];
        cnt_d   = 2'd0;
        acc_d   = '0;
      end else begin
        acc_d = acc_shift;
        if (cnt_q == last_idx) begin
          byte_ld = 1'b1;
          valid_d = 1'b1;
          cnt_d   = 2'd0;
        end else begin
          cnt_d = cnt_q + 2'd1;
        end
      end
    end else if (in_rx_q) begin
      in_rx_d = 1'b0;
      end_d   = 1'b1;
    end
  end

  always_comb begin
    in_st_d = in_st_q;
    sacc_d  = sacc_q;
    stat_ld = 1'b0;
    sv_d    = 1'b0;
    if (ctl == CTL_STATUS) begin
      in_st_d = 1'b1;
      if (in_st_q) sacc_d = {sacc_q[STAT_W-3:0], din[1:0]};
      else         sacc_d = {{(STAT_W-2){1'b0}}, din[1:0]};
    end else if (in_st_q) begin
      in_st_d = 1'b0;
      stat_ld = 1'b1;
      sv_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rx_q <= 1'b0;
      spd_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
      end_q   <= 1'b0;
      in_st_q <= 1'b0;
      sacc_q  <= '0;
      word_q  <= '0;
      sv_q    <= 1'b0;
    end else begin
      in_rx_q <= in_rx_d;
      spd_q   <= spd_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      valid_q <= valid_d;
      end_q   <= end_d;
      in_st_q <= in_st_d;
      sacc_q  <= sacc_d;
      sv_q    <= sv_d;
      if (byte_ld) byte_q <= acc_shift;
      if (stat_ld) word_q <= sacc_q;
    end
  end

  assign rx_byte    = byte_q;
  assign rx_valid   = valid_q;
  assign rx_end     = end_q;
  assign stat_word  = word_q;
  assign stat_valid = sv_q;
endmodule

// File: rtl/phylink_tx.sv
module phylink_tx
  import phylink_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic [1:0]       tx_speed,
  input  logic [LANES-1:0] tx_data,
  input  logic             tx_last,
  input  logic             tx_avail,
  output logic             tx_take,
  output logic             owns,
  output logic [1:0]       ctl_out,
  output logic [LANES-1:0] data_out
);
  localparam int W_LOW = LANES / 4;
  localparam int W_MID = LANES / 2;

  tx_state_e        state_q, state_d;
  logic [1:0]       spd_q, spd_d;
  logic [1:0]       cnt_q, cnt_d;
  logic [1:0]       last_idx;
  logic [LANES-1:0] sh_q, sh_d, sh_adv, slice;
  logic             last_q, last_d;
  logic             take_q, take_d;

  always_comb begin
    case (spd_q)
      SPD_LOW: begin
        slice    = {{(LANES-W_LOW){1'b0}}, sh_q[LANES-1 -: W_LOW]};
        sh_adv   = {sh_q[LANES-W_LOW-1:0], {W_LOW{1'b0}}};
        last_idx = 2'd3;
      end
      SPD_MID: begin
        slice    = {{(LANES-W_MID){1'b0}}, sh_q[LANES-1 -: W_MID]};
        sh_adv   = {sh_q[LANES-W_MID-1:0], {W_MID{1'b0}}};
        last_idx = 2'd1;
      end
      default: begin
        slice    = sh_q;
        sh_adv   = '0;
        last_idx = 2'd0;
      end
    endcase
  end

  always_comb begin
    state_d = state_q;
    spd_d   = spd_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    last_d  = last_q;
    take_d  = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (grant) begin
          if (tx_avail) begin
            state_d = TX_SEND;
            spd_d   = tx_speed;
            sh_d    = tx_data;
            last_d  = tx_last;
            cnt_d   = 2'd0;
            take_d  = 1'b1;
          end else begin
            state_d = TX_CLOSE;
          end
        end
      end
      TX_SEND: begin
        if (cnt_q == last_idx) begin
          if (last_q || !tx_avail) begin
            state_d = TX_CLOSE;
          end else begin
            sh_d   = tx_data;
            last_d = tx_last;
            cnt_d  = 2'd0;
            take_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 2'd1;
          sh_d  = sh_adv;
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      spd_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      last_q  <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      spd_q   <= spd_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      last_q  <= last_d;
      take_q  <= take_d;
    end
  end

  assign owns     = (state_q != TX_IDLE);
  assign ctl_out  = (state_q == TX_SEND) ? CTL_XMIT : CTL_IDLE;
  assign data_out = (state_q == TX_SEND) ? slice : '0;
  assign tx_take  = take_q;
endmodule

// File: rtl/phylink_if.sv
module phylink_if
  import phylink_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int STAT_W = 16,
  parameter int TYPE_W = 3,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctl_in,
  output logic [1:0]        ctl_out,
  output logic              ctl_oe,
  input  logic [LANES-1:0]  data_in,
  output logic [LANES-1:0]  data_out,
  output logic              data_oe,
  output logic              lreq,
  input  logic              req_go,
  input  logic [TYPE_W-1:0] req_type,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_busy,
  input  logic [1:0]        tx_speed,
  input  logic [LANES-1:0]  tx_data,
  input  logic              tx_last,
  input  logic              tx_avail,
  output logic              tx_take,
  output logic [LANES-1:0]  rx_byte,
  output logic              rx_valid,
  output logic              rx_end,
  output logic [STAT_W-1:0] stat_word,
  output logic              stat_valid
);
  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic       owns;
  logic       grant;
  logic [1:0] rx_ctl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  assign grant  = (ctl_in == CTL_XMIT);
  assign rx_ctl = owns ? CTL_IDLE : ctl_in;

  phylink_lreq #(.TYPE_W(TYPE_W), .DATA_W(DATA_W)) u_lreq (
    .clk   (clk),
    .rst_n (rst_sn),
    .go    (req_go),
    .rtype (req_type),
    .rdata (req_data),
    .lreq  (lreq),
    .busy  (req_busy)
  );

  phylink_rx #(.LANES(LANES), .STAT_W(STAT_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_sn),
    .ctl        (rx_ctl),
    .din        (data_in),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .rx_end     (rx_end),
    .stat_word  (stat_word),
    .stat_valid (stat_valid)
  );

  phylink_tx #(.LANES(LANES)) u_tx (
    .clk      (clk),
    .rst_n    (rst_sn),
    .grant    (grant),
    .tx_speed (tx_speed),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .tx_avail (tx_avail),
    .tx_take  (tx_take),
    .owns     (owns),
    .ctl_out  (ctl_out),
    .data_out (data_out)
  );

  assign ctl_oe  = owns;
  assign data_oe = owns;
endmodule

// File: rtl/phylink_if_chk.sv
module phylink_if_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       ctl_in,
  input logic [1:0]       ctl_out,
  input logic             ctl_oe,
  input logic [LANES-1:0] data_out,
  input logic             data_oe,
  input logic             tx_avail,
  input logic             rx_valid,
  input logic             rx_end,
  input logic             stat_valid,
  input logic             lreq,
  input logic             req_busy
);
  p_lreq_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_busy) |-> lreq);
  p_lreq_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_busy |-> !lreq);
  p_rx_in_recv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(ctl_in) == 2'b10);
  p_rx_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> $past(ctl_in) != 2'b10);
  p_stat_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(ctl_in) != 2'b01);
  p_grant_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_oe && ctl_in == 2'b11 && tx_avail) |=> (ctl_oe && ctl_out == 2'b11));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && ctl_out == 2'b00) |=> !ctl_oe);
  p_data_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == '0);
  p_owned_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |=> (!rx_valid && !rx_end && !stat_valid));
endmodule

bind phylink_if phylink_if_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .ctl_in     (ctl_in),
  .ctl_out    (ctl_out),
  .ctl_oe     (ctl_oe),
  .data_out   (data_out),
  .data_oe    (data_oe),
  .tx_avail   (tx_avail),
  .rx_valid   (rx_valid),
  .rx_end     (rx_end),
  .stat_valid (stat_valid),
  .lreq       (lreq),
  .req_busy   (req_busy)
);

// File: tb/phylink_if_test.sv
`timescale 1ns/1ps
module phylink_if_test;
  logic        clk;
  logic        rst_n;
  logic [1:0]  ctl_in;
  logic [1:0]  ctl_out;
  logic        ctl_oe;
  logic [7:0]  data_in;
  logic [7:0]  data_out;
  logic        data_oe;
  logic        lreq;
  logic        req_go;
  logic [2:0]  req_type;
  logic [3:0]  req_data;
  logic        req_busy;
  logic [1:0]  tx_speed;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        tx_avail;
  logic        tx_take;
  logic [7:0]  rx_byte;
  logic        rx_valid;
  logic        rx_end;
  logic [15:0] stat_word;
  logic        stat_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] pkt [0:15];

  phylink_if uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  function automatic int lane_w(input logic [1:0] code);
    return (code == 2'b00) ? 2 : (code == 2'b01) ? 4 : 8;
  endfunction

  function automatic logic [7:0] slice_of(input logic [7:0] b, input int w, input int j);
    return 8'((int'(b) >> (8 - (j + 1) * w)) & ((1 << w) - 1));
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; ctl_in = 2'b00; data_in = '0; req_go = 1'b0; req_type = '0; req_data = '0;
    tx_speed = '0; tx_data = '0; tx_last = 1'b0; tx_avail = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ctl_oe && !data_oe && data_out == 8'h00, "R1", {ctl_oe, data_oe, data_out}, 0);
    chk(!lreq && !req_busy && !tx_take, "R1", {lreq, req_busy, tx_take}, 0);
    chk(!rx_valid && !rx_end && !stat_valid, "R1", {rx_valid, rx_end, stat_valid}, 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk(!ctl_oe && !lreq && !rx_valid, "R1", {ctl_oe, lreq, rx_valid}, 0);
  endtask

  // receive n full bytes at the given speed code, then `partial` extra slices
  task automatic t_rx(input logic [1:0] code, input int n, input int partial);
    int w;
    int ns;
    w  = lane_w(code);
    ns = 8 / w;
    ctl_in  = 2'b10;
    data_in = {6'b0, code};
    step();
    chk(!rx_valid, "R5", rx_valid, 0);
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < ns; j++) begin
        data_in = slice_of(pkt[i], w, j);
        step();
        if (j == ns - 1) chk(rx_valid && rx_byte == pkt[i], "R5", {rx_valid, rx_byte}, {1'b1, pkt[i]});
        else             chk(!rx_valid, "R5", rx_valid, 0);
      end
    end
    for (int p = 0; p < partial; p++) begin
      data_in = slice_of(pkt[n], w, p);
      step();
      chk(!rx_valid, "R6", rx_valid, 0);
    end
    ctl_in  = 2'b00;
    data_in = '0;
    step();
    chk(rx_end && !rx_valid, "R6", {rx_end, rx_valid}, 2'b10);
    step();
    chk(!rx_end, "R6", rx_end, 0);
  endtask

  task automatic t_status(input int n, input logic [31:0] pairs);
    logic [15:0] expw;
    expw = '0;
    ctl_in = 2'b01;
    for (int k = 0; k < n; k++) begin
      data_in = {6'b0, pairs[2*k +: 2]};
      expw    = {expw[13:0], pairs[2*k +: 2]};
      step();
      chk(!stat_valid && !rx_valid, "R2", {stat_valid, rx_valid}, 0);
    end
    ctl_in  = 2'b00;
    data_in = '0;
    step();
    chk(stat_valid && stat_word == expw, "R7", {stat_valid, stat_word}, {1'b1, expw});
    step();
    chk(!stat_valid, "R7", stat_valid, 0);
  endtask

  task automatic t_tx(input logic [1:0] code, input int n);
    int  w;
    int  ns;
    bit  saw;
    w   = lane_w(code);
    ns  = 8 / w;
    saw = 0;
    tx_speed = code; tx_data = pkt[0]; tx_last = (n == 1); tx_avail = 1'b1;
    ctl_in = 2'b11;
    step();
    ctl_in  = 2'b10;     // receive code while link owns: must be ignored (R11)
    data_in = 8'hFF;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < ns; j++) begin
        chk(ctl_oe && data_oe && ctl_out == 2'b11, "R8", {ctl_oe, data_oe, ctl_out}, 4'hF);
        chk(data_out == slice_of(pkt[i], w, j), "R8", data_out, slice_of(pkt[i], w, j));
        if (j == 0) begin
          chk(tx_take, "R8", tx_take, 1);
          if (i + 1 < n) begin
            tx_data = pkt[i + 1];
            tx_last = (i + 1 == n - 1);
          end
        end else begin
          chk(!tx_take, "R8", tx_take, 0);
        end
        if (i == n - 1 && j == ns - 1) begin
          ctl_in  = 2'b00;
          data_in = '0;
        end
        step();
        if (rx_valid || rx_end || stat_valid) saw = 1;
      end
    end
    chk(ctl_oe && data_oe && ctl_out == 2'b00 && data_out == 8'h00, "R9", {ctl_oe, ctl_out, data_out}, 11'h400);
    tx_avail = 1'b0;
    step();
    chk(!ctl_oe && !data_oe, "R9", {ctl_oe, data_oe}, 0);
    chk(!saw && !rx_end, "R11", {saw, rx_end}, 0);
  endtask

  task automatic t_tx_empty();
    tx_avail = 1'b0;
    ctl_in   = 2'b11;
    step();
    ctl_in = 2'b00;
    chk(ctl_oe && ctl_out == 2'b00 && !tx_take, "R10", {ctl_oe, ctl_out, tx_take}, 4'h8);
    step();
    chk(!ctl_oe && !data_oe, "R10", {ctl_oe, data_oe}, 0);
  endtask

  task automatic t_lreq(input logic [2:0] ty, input logic [3:0] dt);
    logic [8:0] frame;
    frame    = {1'b1, ty, dt, 1'b0};
    req_type = ty; req_data = dt; req_go = 1'b1;
    step();
    req_type = ~ty; req_data = ~dt;   // held request during busy: ignored (R4)
    for (int k = 0; k < 9; k++) begin
      chk(req_busy && lreq == frame[8 - k], (k == 0) ? "R3" : "R4", {req_busy, lreq}, {1'b1, frame[8 - k]});
      step();
    end
    req_go = 1'b0;
    chk(!req_busy && !lreq, "R3", {req_busy, lreq}, 0);
    step();
    chk(!req_busy && !lreq, "R3", {req_busy, lreq}, 0);
  endtask

  // request frame and full-width receive in the same cycles
  task automatic t_both();
    logic [8:0] frame;
    frame = {1'b1, 3'b101, 4'b0110, 1'b0};
    for (int k = 0; k < 9; k++) pkt[k] = 8'(8'h31 * (k + 1));
    req_type = 3'b101; req_data = 4'b0110; req_go = 1'b1;
    ctl_in = 2'b10; data_in = 8'h02;
    step();
    req_go = 1'b0;
    for (int k = 0; k < 9; k++) begin
      chk(lreq == frame[8 - k], "R3", lreq, frame[8 - k]);
      data_in = pkt[k];
      step();
      chk(rx_valid && rx_byte == pkt[k], "R5", {rx_valid, rx_byte}, {1'b1, pkt[k]});
    end
    ctl_in = 2'b00; data_in = '0;
    step();
    chk(rx_end && !req_busy, "R6", {rx_end, req_busy}, 2'b10);
  endtask

  initial begin
    t_reset();
    pkt[0] = 8'hA5; pkt[1] = 8'h3C;
    t_rx(2'b00, 2, 0);
    pkt[0] = 8'h96; pkt[1] = 8'h0F; pkt[2] = 8'hE1;
    t_rx(2'b01, 2, 1);
    pkt[0] = 8'h5A; pkt[1] = 8'hC3; pkt[2] = 8'h81;
    t_rx(2'b10, 3, 0);
    pkt[0] = 8'h7E;
    t_rx(2'b11, 1, 0);
    pkt[0] = 8'hB4; pkt[1] = 8'h2D;
    t_rx(2'b00, 1, 3);
    t_status(8, 32'h0000_C6E1);
    t_status(3, 32'h0000_0027);
    pkt[0] = 8'hD2; pkt[1] = 8'h4B;
    t_tx(2'b00, 2);
    pkt[0] = 8'h1E; pkt[1] = 8'hF0; pkt[2] = 8'h69;
    t_tx(2'b01, 3);
    pkt[0] = 8'hAB; pkt[1] = 8'hCD; pkt[2] = 8'hEF;
    t_tx(2'b10, 3);
    t_tx_empty();
    t_lreq(3'b110, 4'b1001);
    t_lreq(3'b001, 4'b0111);
    t_both();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule